// File: doc/BRIEF.md
# Multi-width serial SRAM slave interface

This block is the device-side front end of a byte-wide serial memory. It watches a chip-select line, a serial clock and four data lines, all brought onto one fast system clock through synchronisers and edge detectors. Every selected transfer starts with an 8-bit command. Depending on that command, the block collects a 24-bit address, moves data bytes into or out of a synchronous RAM port, reads or loads an 8-bit mode register, or switches the number of data lanes used per serial clock.

Three lane widths are supported: one bit per clock (input on line 0, output on line 1), two bits per clock on lines 1:0, and four bits per clock on lines 3:0. The selected width is sticky and survives deselection. Each line has its own output enable, and a line is driven only while read data or mode-register data is being shifted out. Reads and writes step through the 17-bit address space one byte at a time and wrap around at the top. A RAM model with a parameterised depth stands in for the array.

Top module: `sram_serial_if`

## Requirements
- R1: After reset, no data line is driven, the lane width is one bit, and a mode-register read returns 40h.
- R2: While chip select is high, all output enables are 0, and any command in progress is abandoned. The next selection starts with a new command.
- R3: Opcode 03h reads. The 8 command bits are followed by 24 address bits, MSB first. Data bytes then leave MSB first, and a new output chunk appears after each falling serial clock. The address steps up by one per byte and wraps from 1FFFFh to 00000h.
- R4: Opcode 02h writes. Each complete data byte received after the address is stored at the current address, and the address then steps up by one.
- R5: Opcode 3Bh selects two-bit lanes. Two bits move per clock, with line 1 carrying the higher bit of each pair. A read inserts 4 dummy clocks between the address and the first data.
- R6: Opcode 38h selects four-bit lanes. Four bits move per clock, with line 3 carrying the highest bit, so the high nibble goes first. A read inserts 2 dummy clocks.
- R7: The lane width set by 3Bh or 38h stays in force across deselection. It returns to one bit only when FFh is received, sent in the width currently selected.
- R8: Opcode 05h drives the mode register immediately after the command, with no address. Opcode 01h loads the next 8 bits received into the mode register.
- R9: The output enables are 0010b in one-bit width, 0011b in two-bit width and 1111b in four-bit width. They are set only during a read-data or register-read phase, and are zero during command, address and dummy clocks.
- R10: If chip select rises before a write byte is complete, that partial byte is discarded and memory is left unchanged.
- R11: An unrecognised opcode is ignored for the rest of the selection: no line is driven and nothing is written.
- R12: The top 7 of the 24 address bits are ignored, so 0xFE0123 and 0x000123 name the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Chip select, active low, asynchronous to clk |
| sck_in | input | 1 | Serial clock, asynchronous to clk |
| sio_in | input | 4 | Data line inputs |
| sio_out | output | 4 | Data line output values |
| sio_oe | output | 4 | Per-line output enables |

## Verification
The corner cases are the ones a lane-width engine tends to get wrong. Address wrap from 1FFFFh to 0 catches a counter that saturates or carries into the ignored upper bits. A partial write byte cut off by chip select catches a design that stores half-shifted data. Dummy-clock counts in two-bit and four-bit reads catch data that appears one chunk early or late, which shows up as a rotated byte. Widths that persist across selections, and the FFh return sent in multi-bit form, catch width state that is cleared on deselection or decoded only on line 0. The bench also checks that the enables stay off through command, address and dummy clocks and for unknown opcodes, so that lines which turn on too early show up as contention.

// File: rtl/sram_sif_pkg.sv
package sram_sif_pkg;

  typedef enum logic [1:0] {
    W_ONE  = 2'd0,
    W_TWO  = 2'd1,
    W_FOUR = 2'd2
  } io_width_e;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_RDATA = 3'd3,
    PH_WDATA = 3'd4,
    PH_MRD   = 3'd5,
    PH_MWR   = 3'd6,
    PH_SKIP  = 3'd7
  } phase_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_FOUR  = 8'h38;
  localparam logic [7:0] OP_TWO   = 8'h3B;
  localparam logic [7:0] OP_ONE   = 8'hFF;
  localparam logic [7:0] OP_MREAD = 8'h05;
  localparam logic [7:0] OP_MLOAD = 8'h01;

  localparam logic [7:0] MODE_RESET = 8'h40;
  localparam int         ADDR_SENT  = 24;

endpackage

// File: rtl/sram_sif_front.sv
module sram_sif_front #(
  parameter int STAGES = 2,
  parameter int LANES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_in,
  input  logic             sck_in,
  input  logic [LANES-1:0] sio_in,
  output logic             cs_s,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic [LANES-1:0] sio_s
);
  localparam int W = LANES + 2;
  localparam logic [W-1:0] RST_V = {1'b1, 1'b0, {LANES{1'b0}}};

  logic [W-1:0] chain [STAGES];
  logic         sck_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_V;
          else        chain[g] <= {cs_n_in, sck_in, sio_in};
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_V;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= chain[STAGES-1][LANES];
  end

  assign cs_s     = chain[STAGES-1][LANES+1];
  assign sio_s    = chain[STAGES-1][LANES-1:0];
  assign sck_rise =  chain[STAGES-1][LANES] & ~sck_d;
  assign sck_fall = ~chain[STAGES-1][LANES] &  sck_d;
endmodule

// File: rtl/sram_sif_ram.sv
module sram_sif_ram #(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];
  logic       unused_hi;

  assign unused_hi = ^{waddr[ADDR_W-1:MEM_AW], raddr[ADDR_W-1:MEM_AW]};

  always_ff @(posedge clk) begin
    if (we) mem[waddr[MEM_AW-1:0]] <= wdata;
    q <= mem[raddr[MEM_AW-1:0]];
  end
endmodule

// File: rtl/sram_sif_ctrl.sv
module sram_sif_ctrl
  import sram_sif_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [3:0]        sio_s,
  input  logic [7:0]        ram_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe,
  output io_width_e         width
);
  phase_e            phase_q, phase_n;
  io_width_e         width_q, width_n;
  logic [4:0]        cnt_q, cnt_n;
  logic [ADDR_W-1:0] rx_q, rx_n, rx_nxt;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              is_rd_q, is_rd_n;
  logic [7:0]        tx_q, tx_n;
  logic [2:0]        chunk_q, chunk_n;
  logic [3:0]        out_q, out_n, oe_q, oe_n;
  logic [7:0]        mode_q, mode_n;
  logic              we_q, we_n;
  logic [7:0]        wd_q, wd_n;
  logic [ADDR_W-1:0] wa_q, wa_n;

  logic [4:0] per_byte, addr_len, dummy_len;
  logic [3:0] lane_mask;
  logic [7:0] cur_b, src_b;
  logic [3:0] out_v;
  logic       unused_top;

  assign unused_top = rx_q[ADDR_W-1];

  always_comb begin
    unique case (width_q)
      W_TWO: begin
        per_byte = 5'd4; addr_len = 5'd12; dummy_len = 5'd4; lane_mask = 4'b0011;
        rx_nxt = {rx_q[ADDR_W-3:0], sio_s[1:0]};
      end
      W_FOUR: begin
        per_byte = 5'd2; addr_len = 5'd6; dummy_len = 5'd2; lane_mask = 4'b1111;
        rx_nxt = {rx_q[ADDR_W-5:0], sio_s[3:0]};
      end
      default: begin
        per_byte = 5'd8; addr_len = 5'(ADDR_SENT); dummy_len = 5'd0; lane_mask = 4'b0010;
        rx_nxt = {rx_q[ADDR_W-2:0], sio_s[0]};
      end
    endcase
  end

  always_comb begin
    src_b = (phase_q == PH_RDATA) ? ram_q : mode_q;
    cur_b = (chunk_q == 3'd0) ? src_b : tx_q;
    unique case (width_q)
      W_TWO:   out_v = {2'b00, cur_b[7:6]};
      W_FOUR:  out_v = cur_b[7:4];
      default: out_v = {2'b00, cur_b[7], 1'b0};
    endcase
  end

  always_comb begin
    phase_n = phase_q;  width_n = width_q; cnt_n   = cnt_q;
    rx_n    = rx_q;     addr_n  = addr_q;  is_rd_n = is_rd_q;
    tx_n    = tx_q;     chunk_n = chunk_q; out_n   = out_q;
    oe_n    = oe_q;     mode_n  = mode_q;  we_n    = 1'b0;
    wd_n    = wd_q;     wa_n    = wa_q;
    if (cs_s) begin
      phase_n = PH_CMD; cnt_n = 5'd0; chunk_n = 3'd0;
      out_n   = 4'd0;   oe_n  = 4'd0;
    end else if (sck_rise) begin
      rx_n  = rx_nxt;
      cnt_n = cnt_q + 5'd1;
      unique case (phase_q)
        PH_CMD: if (cnt_q + 5'd1 == per_byte) begin
          cnt_n = 5'd0;
          unique case (rx_nxt[7:0])
            OP_READ:  begin phase_n = PH_ADDR; is_rd_n = 1'b1; end
            OP_WRITE: begin phase_n = PH_ADDR; is_rd_n = 1'b0; end
            OP_MREAD: phase_n = PH_MRD;
            OP_MLOAD: phase_n = PH_MWR;
            OP_FOUR:  begin phase_n = PH_SKIP; width_n = W_FOUR; end
            OP_TWO:   begin phase_n = PH_SKIP; width_n = W_TWO;  end
            OP_ONE:   begin phase_n = PH_SKIP; width_n = W_ONE;  end
            default:  phase_n = PH_SKIP;
          endcase
        end
        PH_ADDR: if (cnt_q + 5'd1 == addr_len) begin
          cnt_n  = 5'd0;
          addr_n = rx_nxt;
          if (!is_rd_q)            phase_n = PH_WDATA;
          else if (dummy_len == 0) phase_n = PH_RDATA;
          else                     phase_n = PH_DUMMY;
        end
        PH_DUMMY: if (cnt_q + 5'd1 == dummy_len) begin
          cnt_n = 5'd0; phase_n = PH_RDATA;
        end
        PH_WDATA: if (cnt_q + 5'd1 == per_byte) begin
          cnt_n  = 5'd0;
          we_n   = 1'b1;
          wd_n   = rx_nxt[7:0];
          wa_n   = addr_q;
          addr_n = addr_q + 1'b1;
        end
        PH_MWR: if (cnt_q + 5'd1 == per_byte) begin
          cnt_n = 5'd0; mode_n = rx_nxt[7:0]; phase_n = PH_SKIP;
        end
        default: cnt_n = cnt_q;
      endcase
    end else if (sck_fall && (phase_q == PH_RDATA || phase_q == PH_MRD)) begin
      out_n   = out_v;
      oe_n    = lane_mask;
      tx_n    = cur_b << per_byte[4:3] << (width_q == W_ONE ? 0 : (width_q == W_TWO ? 2 : 4));
      chunk_n = (5'(chunk_q) + 5'd1 == per_byte) ? 3'd0 : chunk_q + 3'd1;
      if (chunk_q == 3'd0 && phase_q == PH_RDATA) addr_n = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;  width_q <= W_ONE;       cnt_q   <= 5'd0;
      rx_q    <= '0;      addr_q  <= '0;          is_rd_q <= 1'b0;
      tx_q    <= 8'd0;    chunk_q <= 3'd0;        out_q   <= 4'd0;
      oe_q    <= 4'd0;    mode_q  <= MODE_RESET;  we_q    <= 1'b0;
      wd_q    <= 8'd0;    wa_q    <= '0;
    end else begin
      phase_q <= phase_n; width_q <= width_n;     cnt_q   <= cnt_n;
      rx_q    <= rx_n;    addr_q  <= addr_n;      is_rd_q <= is_rd_n;
      tx_q    <= tx_n;    chunk_q <= chunk_n;     out_q   <= out_n;
      oe_q    <= oe_n;    mode_q  <= mode_n;      we_q    <= we_n;
      wd_q    <= wd_n;    wa_q    <= wa_n;
    end
  end

  assign rd_addr = addr_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sio_out = out_q;
  assign sio_oe  = oe_q;
  assign width   = width_q;
endmodule

// File: rtl/sram_serial_if.sv
module sram_serial_if
  import sram_sif_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_in,
  input  logic       sck_in,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe
);
  logic              rst_m, rst_sn;
  logic              cs_s, sck_rise, sck_fall;
  logic [3:0]        sio_s;
  logic [7:0]        ram_q, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              ram_we;
  io_width_e         width_e;
  logic [1:0]        cur_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  sram_sif_front #(.STAGES(SYNC_STAGES), .LANES(4)) u_front (
    .clk(clk), .rst_n(rst_sn), .cs_n_in(cs_n_in), .sck_in(sck_in), .sio_in(sio_in),
    .cs_s(cs_s), .sck_rise(sck_rise), .sck_fall(sck_fall), .sio_s(sio_s)
  );

  sram_sif_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .cs_s(cs_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sio_s(sio_s), .ram_q(ram_q), .rd_addr(rd_addr), .wr_en(ram_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .sio_out(sio_out), .sio_oe(sio_oe), .width(width_e)
  );

  sram_sif_ram #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wr_addr), .wdata(wr_data), .raddr(rd_addr), .q(ram_q)
  );

  assign cur_width = width_e;
endmodule

// File: rtl/sram_serial_if_chk.sv
module sram_serial_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sck_rise,
  input logic       sck_fall,
  input logic       ram_we,
  input logic [1:0] width,
  input logic [3:0] sio_out,
  input logic [3:0] sio_oe
);
  // R2: deselection releases every line
  p_idle_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (sio_oe == 4'b0000));

  // R9: only the three lane masks or nothing
  p_oe_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'b0000) || (sio_oe == 4'b0010) || (sio_oe == 4'b0011) || (sio_oe == 4'b1111));

  // R3: output values move only after a falling serial clock or deselection
  p_out_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_s) |=> ($stable(sio_out) && $stable(sio_oe)));

  // R7: width never changes while deselected or without a rising serial clock
  p_width_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s || !sck_rise) |=> $stable(width));

  // R4: a RAM write follows a sampled rising serial clock
  p_we_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(sck_rise));
endmodule

bind sram_serial_if sram_serial_if_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .cs_s(cs_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
  .ram_we(ram_we), .width(cur_width), .sio_out(sio_out), .sio_oe(sio_oe)
);

// File: tb/sram_serial_if_tb.sv
module sram_serial_if_tb;
  localparam int HALF = 6;
  localparam int NVEC = 8;
  // {width[33:32], address[31:8], data[7:0]}; width 0=one, 1=two, 2=four
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 24'h000010, 8'h3C},
    {2'd0, 24'h01ABCD, 8'h5A},
    {2'd1, 24'h000020, 8'hC3},
    {2'd1, 24'h00F00F, 8'h96},
    {2'd2, 24'h000030, 8'hE7},
    {2'd2, 24'h1FFFFE, 8'h18},
    {2'd0, 24'h000040, 8'h81},
    {2'd1, 24'h000021, 8'h44}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sck;
  logic [3:0] sio_in;
  logic [3:0] sio_out, sio_oe;

  int checks = 0;
  int errors = 0;
  int cur_w  = 0;
  bit done   = 1'b0;
  logic [3:0] oe_acc;

  always #4 clk = ~clk;

  sram_serial_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sck_in(sck),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sck_cycle(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    sio_in = d;
    repeat (HALF) @(negedge clk);
    q  = sio_out;
    oe = sio_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  function automatic int bits_per(input int w);
    return (w == 0) ? 1 : ((w == 1) ? 2 : 4);
  endfunction

  task automatic send_byte(input logic [7:0] b);
    int bw = bits_per(cur_w);
    logic [7:0] s = b;
    logic [3:0] q, oe, d;
    for (int i = 0; i < 8 / bw; i++) begin
      d = (bw == 1) ? {3'b0, s[7]} : ((bw == 2) ? {2'b0, s[7:6]} : s[7:4]);
      s = s << bw;
      sck_cycle(d, q, oe);
      oe_acc |= oe;
    end
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic [3:0] oe_or);
    int bw = bits_per(cur_w);
    logic [3:0] q, oe;
    b = 8'd0; oe_or = 4'd0;
    for (int i = 0; i < 8 / bw; i++) begin
      sck_cycle(4'd0, q, oe);
      oe_or |= oe;
      if (bw == 1)      b = {b[6:0], q[1]};
      else if (bw == 2) b = {b[5:0], q[1:0]};
      else              b = {b[3:0], q[3:0]};
    end
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_n = 1'b0;
    oe_acc = 4'd0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic set_width(input int tw);
    if (tw == cur_w) return;
    if (cur_w != 0) begin
      cs_begin(); send_byte(8'hFF); cs_end(); cur_w = 0;
    end
    if (tw == 1) begin cs_begin(); send_byte(8'h3B); cs_end(); cur_w = 1; end
    if (tw == 2) begin cs_begin(); send_byte(8'h38); cs_end(); cur_w = 2; end
  endtask

  task automatic wr_bytes(input logic [23:0] a, input logic [7:0] b0, input logic [7:0] b1, input int n);
    cs_begin(); send_byte(8'h02); send_addr(a);
    send_byte(b0);
    if (n > 1) send_byte(b1);
    cs_end();
  endtask

  task automatic rd_start(input logic [23:0] a);
    logic [3:0] q, oe;
    cs_begin(); send_byte(8'h03); send_addr(a);
    for (int i = 0; i < ((cur_w == 1) ? 4 : ((cur_w == 2) ? 2 : 0)); i++) begin
      sck_cycle(4'd0, q, oe);
      oe_acc |= oe;
    end
  endtask

  function automatic logic [3:0] mask_of(input int w);
    return (w == 0) ? 4'b0010 : ((w == 1) ? 4'b0011 : 4'b1111);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [3:0] oe;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sio_in = 4'd0; oe_acc = 4'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 R2: idle after reset
    chk("R1 R2 reset oe", {28'd0, sio_oe}, 32'h0);
    cs_begin(); send_byte(8'h05); recv_byte(b, oe); cs_end();
    chk("R1 R8 mode reset value", {24'd0, b}, 32'h40);
    chk("R9 one-bit register read enables", {28'd0, oe}, 32'h2);
    chk("R2 oe after deselect", {28'd0, sio_oe}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      set_width(int'(VEC[i][33:32]));
      wr_bytes(VEC[i][31:8], VEC[i][7:0], 8'h00, 1);
      rd_start(VEC[i][31:8]);
      chk("R9 no drive in command/address/dummy", {28'd0, oe_acc}, 32'h0);
      recv_byte(b, oe);
      cs_end();
      chk("R3 R4 R5 R6 readback", {24'd0, b}, {24'd0, VEC[i][7:0]});
      chk("R9 lane enables", {28'd0, oe}, {28'd0, mask_of(cur_w)});
    end

    // R7: last table width was two-bit; it survived several selections above.
    set_width(0);
    rd_start(24'h000010); recv_byte(b, oe); cs_end();
    chk("R7 return to one bit via FFh", {24'd0, b}, 32'h3C);

    // R3: wrap from the top address to zero, sequential bytes
    wr_bytes(24'h01FFFF, 8'hA1, 8'hB2, 2);
    rd_start(24'h000000); recv_byte(b, oe); cs_end();
    chk("R3 write wrapped to address 0", {24'd0, b}, 32'hB2);
    rd_start(24'h01FFFF); recv_byte(b, oe);
    chk("R3 first byte at top", {24'd0, b}, 32'hA1);
    recv_byte(b, oe); cs_end();
    chk("R3 read wrapped to address 0", {24'd0, b}, 32'hB2);

    // R12: ignored upper address bits
    wr_bytes(24'hFE0123, 8'h7E, 8'h00, 1);
    rd_start(24'h000123); recv_byte(b, oe); cs_end();
    chk("R12 upper address bits ignored", {24'd0, b}, 32'h7E);

    // R10: partial byte thrown away
    wr_bytes(24'h000200, 8'h11, 8'h00, 1);
    cs_begin(); send_byte(8'h02); send_addr(24'h000200);
    for (int i = 0; i < 5; i++) begin
      logic [3:0] q, o;
      sck_cycle(4'h1, q, o);
    end
    cs_end();
    rd_start(24'h000200); recv_byte(b, oe); cs_end();
    chk("R10 partial byte discarded", {24'd0, b}, 32'h11);

    // R11: unknown opcode, then lines stay idle and memory untouched
    cs_begin(); send_byte(8'h77);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] q, o;
      sck_cycle(4'hF, q, o);
      oe_acc |= o;
    end
    chk("R11 no drive after unknown opcode", {28'd0, oe_acc}, 32'h0);
    cs_end();
    rd_start(24'h000200); recv_byte(b, oe); cs_end();
    chk("R11 memory untouched", {24'd0, b}, 32'h11);

    // R8 R6: mode register in four-bit width
    set_width(2);
    cs_begin(); send_byte(8'h01); send_byte(8'hA5); cs_end();
    cs_begin(); send_byte(8'h05); recv_byte(b, oe); cs_end();
    chk("R8 mode register load/read", {24'd0, b}, 32'hA5);
    chk("R9 four-bit register read enables", {28'd0, oe}, 32'hF);

    // R7: FFh sent in four-bit form returns to one bit
    set_width(0);
    rd_start(24'h000123); recv_byte(b, oe); cs_end();
    chk("R7 one-bit read after four-bit", {24'd0, b}, 32'h7E);
    chk("R2 idle at end", {28'd0, sio_oe}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule